// File: doc/BRIEF.md
# Hierarchical Coherence Directory Controller

This block sits between two levels of a tree of snooping buses and holds only coherence status, never data. For every item it tracks one of six states: I (absent below), E (only copy lives below), S (copies below, maybe elsewhere too), R (a read from below was sent upward), W (an erase from below was sent upward) and A (this subtree promised to answer a read from above). Requests move up the tree only when the subtree cannot satisfy them. Requests move down only when the subtree has to act on them. R and A leave a trail, so replies find their way back along the same path. A second read that meets this trail is absorbed, not sent again.

Traffic snooped on the lower bus is pushed into an input queue and looked up when there is time. Traffic on the upper bus is looked up as soon as the lower output queue can take the result, and it has priority over the input queue. Results leave through two separate queues, one toward the upper bus and one toward the lower bus. The status store is a direct-indexed table: the low address bits select an entry, and the entry holds a tag and a state.

Transaction codes on every op field are: 0 read, 1 data, 2 erase, 3 exclusive acknowledge.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, no output queue presents a transaction, both ready outputs are high, and every item reads as I.
- R2: A read from below for an item in I sends a read (code 0) to the upper queue and moves the item to R. A read from below for an item in E or S produces no output.
- R3: A read from above for an item in E or S moves it to A and sends a read down. A read from above for an item in I produces no output.
- R4: Data (code 1) from below for an item in A is sent up, and the item becomes S. Data from above for an item in R is sent down, and the item becomes S.
- R5: A read from either side that meets an item in R or A produces no output and leaves the state unchanged.
- R6: An erase (code 2) from below for an item in E sends an exclusive acknowledge (code 3) down, and the item stays E. An erase from below for an item in S or I sends the erase up and moves the item to W.
- R7: An exclusive acknowledge from above for an item in W moves it to E and sends the acknowledge down.
- R8: An erase from above for an item in E, S or W moves it to I and sends the erase down.
- R9: Every other pair of state and transaction produces no output and leaves the state unchanged.
- R10: The table is indexed by the low IDXW address bits. An entry whose tag differs from the address reads as I, and any state change overwrites that entry with the new tag.
- R11: At most one lookup happens per cycle, and a transaction from above wins over the input queue. The head of the input queue is processed only when both output queues have room. The input queue keeps arrival order.
- R12: lo_ready is high exactly when the input queue is not full, and up_ready is high exactly when the lower output queue is not full. An output queue never takes a transaction while full.

State transitions: I→R (read below), E/S→A (read above), A→S (data below), R→S (data above), S/I→W (erase below), W→E (exclusive above), E/S/W→I (erase above).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_valid | input | 1 | Transaction snooped on the lower bus |
| lo_op | input | 2 | Its transaction code |
| lo_addr | input | AW | Its item address |
| lo_ready | output | 1 | Input queue can take a transaction |
| up_valid | input | 1 | Transaction snooped on the upper bus |
| up_op | input | 2 | Its transaction code |
| up_addr | input | AW | Its item address |
| up_ready | output | 1 | Upper transaction accepted this cycle |
| oa_valid | output | 1 | Upper output queue has a transaction |
| oa_op | output | 2 | Code of its head |
| oa_addr | output | AW | Address of its head |
| oa_ready | input | 1 | Upper bus takes the head |
| ob_valid | output | 1 | Lower output queue has a transaction |
| ob_op | output | 2 | Code of its head |
| ob_addr | output | AW | Address of its head |
| ob_ready | input | 1 | Lower bus takes the head |

## Verification
A transaction from above is looked up on the same edge that accepts it, so its result shows at the lower queue head one cycle later. A transaction from below spends one edge entering the input queue and one more being looked up, so its result shows two cycles after it is driven when the queue is otherwise idle. The bench sends one transaction at a time, waits three cycles with both output readies low, and then compares both queue heads with the reference model's prediction. This leaves margin on both paths. In the back-pressure test the upper queue is held full and the bench checks the order in which the held entries drain.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_DATA  = 2'd1,
        OP_ERASE = 2'd2,
        OP_EXCL  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_E = 3'd1,
        ST_S = 3'd2,
        ST_R = 3'd3,
        ST_W = 3'd4,
        ST_A = 3'd5
    } st_e;
endpackage

// File: rtl/dir_fifo.sv
module dir_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout      = mem[rd_ptr];
    assign not_empty = (cnt != '0);
    assign full      = (cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH)));  // R12
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));  // R11
endmodule

// File: rtl/dir_table.sv
module dir_table
    import coh_dir_pkg::*;
#(
    parameter int IDXW = 4,
    parameter int TAGW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [TAGW-1:0] rd_tag,
    output st_e             rd_state,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [TAGW-1:0] wr_tag,
    input  st_e             wr_state
);
    localparam int ENTRIES = 1 << IDXW;

    st_e             st_q  [ENTRIES];
    logic [TAGW-1:0] tag_q [ENTRIES];

    assign rd_state = (tag_q[rd_idx] == rd_tag) ? st_q[rd_idx] : ST_I;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) begin
                st_q[k]  <= ST_I;
                tag_q[k] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]  <= wr_state;
            tag_q[wr_idx] <= wr_tag;
        end
    end
endmodule

// File: rtl/dir_fsm.sv
module dir_fsm
    import coh_dir_pkg::*;
(
    input  st_e  cur,
    input  op_e  op,
    input  logic from_above,
    output st_e  nxt,
    output logic emit_up,
    output logic emit_dn,
    output op_e  out_op,
    output logic upd
);
    always_comb begin
        nxt     = cur;
        emit_up = 1'b0;
        emit_dn = 1'b0;
        out_op  = op;
        if (!from_above) begin
            unique case (op)
                OP_READ: if (cur == ST_I) begin
                    nxt = ST_R; emit_up = 1'b1;
                end
                OP_DATA: if (cur == ST_A) begin
                    nxt = ST_S; emit_up = 1'b1;
                end
                OP_ERASE: begin
                    if (cur == ST_E) begin
                        emit_dn = 1'b1; out_op = OP_EXCL;
                    end else if (cur == ST_S || cur == ST_I) begin
                        nxt = ST_W; emit_up = 1'b1;
                    end
                end
                OP_EXCL: ;
            endcase
        end else begin
            unique case (op)
                OP_READ: if (cur == ST_E || cur == ST_S) begin
                    nxt = ST_A; emit_dn = 1'b1;
                end
                OP_DATA: if (cur == ST_R) begin
                    nxt = ST_S; emit_dn = 1'b1;
                end
                OP_ERASE: if (cur == ST_E || cur == ST_S || cur == ST_W) begin
                    nxt = ST_I; emit_dn = 1'b1;
                end
                OP_EXCL: if (cur == ST_W) begin
                    nxt = ST_E; emit_dn = 1'b1;
                end
            endcase
        end
        upd = (nxt != cur);
    end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int AW    = 8,
    parameter int IDXW  = 4,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_valid,
    input  logic [1:0]    lo_op,
    input  logic [AW-1:0] lo_addr,
    output logic          lo_ready,
    input  logic          up_valid,
    input  logic [1:0]    up_op,
    input  logic [AW-1:0] up_addr,
    output logic          up_ready,
    output logic          oa_valid,
    output logic [1:0]    oa_op,
    output logic [AW-1:0] oa_addr,
    input  logic          oa_ready,
    output logic          ob_valid,
    output logic [1:0]    ob_op,
    output logic [AW-1:0] ob_addr,
    input  logic          ob_ready
);
    localparam int TAGW = AW - IDXW;
    localparam int TW   = AW + 2;

    logic          ib_nempty, ib_full, oa_full, ob_full;
    logic [TW-1:0] ib_dout, oa_dout, ob_dout, out_word;
    logic          proc_up, proc_lo, fire;
    logic [AW-1:0] sel_addr;
    op_e           sel_op, out_op;
    st_e           cur_st, nxt_st;
    logic          emit_up, emit_dn, upd;
    logic          oa_push, ob_push;

    assign lo_ready = !ib_full;
    assign up_ready = !ob_full;

    dir_fifo #(.W(TW), .DEPTH(QDEPTH)) u_ib (
        .clk(clk), .rst_n(rst_n),
        .push(lo_valid && !ib_full), .din({lo_op, lo_addr}),
        .pop(proc_lo), .dout(ib_dout),
        .not_empty(ib_nempty), .full(ib_full)
    );

    assign proc_up  = up_valid && !ob_full;
    assign proc_lo  = !proc_up && ib_nempty && !oa_full && !ob_full;
    assign fire     = proc_up || proc_lo;
    assign sel_addr = proc_up ? up_addr : ib_dout[AW-1:0];
    assign sel_op   = op_e'(proc_up ? up_op : ib_dout[TW-1:AW]);

    dir_table #(.IDXW(IDXW), .TAGW(TAGW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(sel_addr[IDXW-1:0]), .rd_tag(sel_addr[AW-1:IDXW]),
        .rd_state(cur_st),
        .wr_en(fire && upd),
        .wr_idx(sel_addr[IDXW-1:0]), .wr_tag(sel_addr[AW-1:IDXW]),
        .wr_state(nxt_st)
    );

    dir_fsm u_fsm (
        .cur(cur_st), .op(sel_op), .from_above(proc_up),
        .nxt(nxt_st), .emit_up(emit_up), .emit_dn(emit_dn),
        .out_op(out_op), .upd(upd)
    );

    assign out_word = {out_op, sel_addr};
    assign oa_push  = proc_lo && emit_up;
    assign ob_push  = fire && emit_dn;

    dir_fifo #(.W(TW), .DEPTH(QDEPTH)) u_oa (
        .clk(clk), .rst_n(rst_n),
        .push(oa_push), .din(out_word),
        .pop(oa_valid && oa_ready), .dout(oa_dout),
        .not_empty(oa_valid), .full(oa_full)
    );

    dir_fifo #(.W(TW), .DEPTH(QDEPTH)) u_ob (
        .clk(clk), .rst_n(rst_n),
        .push(ob_push), .din(out_word),
        .pop(ob_valid && ob_ready), .dout(ob_dout),
        .not_empty(ob_valid), .full(ob_full)
    );

    assign oa_op   = oa_dout[TW-1:AW];
    assign oa_addr = oa_dout[AW-1:0];
    assign ob_op   = ob_dout[TW-1:AW];
    assign ob_addr = ob_dout[AW-1:0];

    AST_READ_UP_FROM_I: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_lo && sel_op == OP_READ && cur_st == ST_I)
        |-> (oa_push && out_op == OP_READ));  // R2
    AST_EXCL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_up && sel_op == OP_EXCL && cur_st == ST_W)
        |-> (ob_push && out_op == OP_EXCL));  // R7
    AST_ERASE_FROM_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_up && sel_op == OP_ERASE &&
         (cur_st == ST_E || cur_st == ST_S || cur_st == ST_W))
        |-> ob_push);  // R8
    AST_COMBINE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel_op == OP_READ && (cur_st == ST_R || cur_st == ST_A))
        |-> (!oa_push && !ob_push));  // R5
    AST_ONE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({proc_up, proc_lo}));  // R11
endmodule

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lo_valid, up_valid, oa_ready, ob_ready;
    logic [1:0]    lo_op, up_op;
    logic [AW-1:0] lo_addr, up_addr;
    logic          lo_ready, up_ready, oa_valid, ob_valid;
    logic [1:0]    oa_op, ob_op;
    logic [AW-1:0] oa_addr, ob_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model: states 0 I,1 E,2 S,3 R,4 W,5 A
    int m_st  [16];
    int m_tag [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .lo_valid(lo_valid), .lo_op(lo_op), .lo_addr(lo_addr), .lo_ready(lo_ready),
        .up_valid(up_valid), .up_op(up_op), .up_addr(up_addr), .up_ready(up_ready),
        .oa_valid(oa_valid), .oa_op(oa_op), .oa_addr(oa_addr), .oa_ready(oa_ready),
        .ob_valid(ob_valid), .ob_op(ob_op), .ob_addr(ob_addr), .ob_ready(ob_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input bit above, input int op, input int addr,
                         output bit eu, output bit ed, output int eop);
        int idx, tg, cur, nx;
        idx = addr & 15; tg = addr >> 4;
        cur = (m_tag[idx] == tg) ? m_st[idx] : 0;
        nx = cur; eu = 0; ed = 0; eop = op;
        if (!above) begin
            if (op == 0 && cur == 0) begin nx = 3; eu = 1; end
            else if (op == 1 && cur == 5) begin nx = 2; eu = 1; end
            else if (op == 2 && cur == 1) begin ed = 1; eop = 3; end
            else if (op == 2 && (cur == 2 || cur == 0)) begin nx = 4; eu = 1; end
        end else begin
            if (op == 0 && (cur == 1 || cur == 2)) begin nx = 5; ed = 1; end
            else if (op == 1 && cur == 3) begin nx = 2; ed = 1; end
            else if (op == 2 && (cur == 1 || cur == 2 || cur == 4)) begin nx = 0; ed = 1; end
            else if (op == 3 && cur == 4) begin nx = 1; ed = 1; end
        end
        if (nx != cur) begin m_st[idx] = nx; m_tag[idx] = tg; end
    endtask

    task automatic send(input bit above, input int op, input int addr, input string req);
        bit eu, ed; int eop;
        model(above, op, addr, eu, ed, eop);
        @(negedge clk);
        if (above) begin up_valid = 1; up_op = 2'(op); up_addr = AW'(addr); end
        else begin lo_valid = 1; lo_op = 2'(op); lo_addr = AW'(addr); end
        @(negedge clk);
        up_valid = 0; lo_valid = 0;
        repeat (3) @(negedge clk);
        chk(oa_valid == eu, {req, " upper queue presence"}, oa_valid, eu);
        if (eu && oa_valid)
            chk(oa_op == 2'(eop) && oa_addr == AW'(addr), {req, " upper queue head"},
                {oa_op, oa_addr}, {eop[1:0], addr[7:0]});
        chk(ob_valid == ed, {req, " lower queue presence"}, ob_valid, ed);
        if (ed && ob_valid)
            chk(ob_op == 2'(eop) && ob_addr == AW'(addr), {req, " lower queue head"},
                {ob_op, ob_addr}, {eop[1:0], addr[7:0]});
        if (oa_valid) begin oa_ready = 1; @(negedge clk); oa_ready = 0; end
        if (ob_valid) begin ob_ready = 1; @(negedge clk); ob_ready = 0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit eu, ed; int eop;
        lo_valid = 0; up_valid = 0; oa_ready = 0; ob_ready = 0;
        lo_op = 0; up_op = 0; lo_addr = 0; up_addr = 0;
        for (int k = 0; k < 16; k++) begin m_st[k] = 0; m_tag[k] = 0; end
        void'($urandom(32'd2024));
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!oa_valid && !ob_valid, "R1 queues empty", {oa_valid, ob_valid}, 0);
        chk(lo_ready && up_ready, "R1 ready high", {lo_ready, up_ready}, 3);

        // directed walk on one item, then a conflicting tag
        send(0, 0, 'h10, "R2 read below in I");
        send(0, 0, 'h10, "R5 read below in R combined");
        send(1, 1, 'h10, "R4 data above in R");
        send(0, 0, 'h10, "R2 read below in S silent");
        send(0, 2, 'h10, "R6 erase below in S");
        send(1, 3, 'h10, "R7 exclusive above in W");
        send(0, 2, 'h10, "R6 erase below in E");
        send(1, 0, 'h10, "R3 read above in E");
        send(1, 0, 'h10, "R5 read above in A combined");
        send(0, 1, 'h10, "R4 data below in A");
        send(1, 0, 'h11, "R3 read above in I");
        send(0, 2, 'h12, "R6 erase below in I");
        send(1, 2, 'h12, "R8 erase above in W");
        send(0, 0, 'h20, "R10 other tag reads I");
        send(1, 2, 'h10, "R10 evicted tag reads I");
        send(0, 1, 'h20, "R9 data below not in A");
        send(1, 3, 'h20, "R9 exclusive above not in W");

        // constrained random on idx 0..3, tags 0..1
        for (int n = 0; n < 400; n++) begin
            int a, o; bit s;
            a = (($urandom % 2) << 4) | ($urandom % 4);
            o = $urandom % 4;
            s = 1'($urandom % 2);
            send(s, o, a, "RAND");
        end

        // back-pressure: 8 reads to idx 8..15, upper queue held
        for (int k = 8; k < 16; k++) begin
            model(0, 0, k, eu, ed, eop);
            @(negedge clk);
            lo_valid = 1; lo_op = 0; lo_addr = AW'(k);
        end
        @(negedge clk);
        lo_valid = 0;
        repeat (4) @(negedge clk);
        chk(lo_ready == 0, "R12 input queue full drops ready", lo_ready, 0);
        chk(up_ready == 1, "R12 upper side still ready", up_ready, 1);
        for (int k = 8; k < 16; k++) begin
            chk(oa_valid && oa_addr == AW'(k), "R11 drain order",
                oa_addr, k);
            oa_ready = 1; @(negedge clk); oa_ready = 0;
            @(negedge clk);
        end
        chk(!oa_valid && !ob_valid, "R11 queues drained", {oa_valid, ob_valid}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule